// File: doc/BRIEF.md
# Pseudo-SRAM Low-Power Mode Controller

This block governs the power-saving behaviour of a pseudo-static RAM model. A single five-bit configuration register selects one of three standby behaviours: shrinking the usable array, restricting self-refresh to part of the array, or entering deep sleep. The register is loaded only during a short window that opens when the active-low sleep pin falls. The window length is a parameter given in clock cycles and stands for one microsecond at the system clock rate.

The controller paces a refresh row counter. The counter's wrap point follows the active partial-refresh size while the pin is low and covers the full array while it is high. A combinational address check reports whether an access falls inside the capacity that reduced-size mode allows. A ready flag tells the host when the array may be accessed, and it includes a parameterised wake-up delay after deep sleep.

The register layout is {valid, mode[1:0], size[1:0]}. Mode codes are 00 none, 01 reduced size, 10 partial refresh and 11 deep sleep. Size codes are 00 full, 01 three quarters, 10 one half and 11 one quarter, so the allowed number of quarters is 4 minus the size code.

Top module: `psr_lowpower_ctrl`

## Requirements
- R1: A write on `cfg_we` with the pin low is stored when it is sampled at one of the first WIN_CYC rising clock edges that see `sleep_n` low. The register is {valid[4], mode[3:2], size[1:0]}.
- R2: A write outside that window is ignored, either later in the low period or with the pin high. From the next cycle on, `cfg_err` is 1, and it stays 1 until reset.
- R3: `addr_ok` is 1 exactly when the top two address bits are below the allowed quarter count. That count is 4, 3, 2 or 1 for size codes 00, 01, 10 and 11.
- R4: Reduced-size mode takes effect only at the first clock edge that sees the pin high after a low period, and only if the stored register is valid with mode 01. Otherwise the full array is restored at that edge. The limit holds through later low periods that carry no write.
- R5: Outside deep sleep `ref_req` follows `ref_tick`. Each issued request advances `ref_row` by one on the next edge, and the row wraps to 0 after its last value. With the pin high the last row is 2^ROW_W-1.
- R6: In standby with a valid mode-10 register, the row wraps after row quarters*2^(ROW_W-2)-1. A row already at or above that bound returns to 0. Once the pin is high again, the full range applies.
- R7: Without a valid register, a low period of WIN_CYC edges brings the block into standby (`par_active`=1) with full-range refresh. Deep sleep is never entered.
- R8: With a valid mode-11 register, `deep_sleep` rises one cycle after standby is entered. While it is set, `ref_req` is 0 whatever `ref_tick` does.
- R9: `ready` is 0 from the cycle after the pin is seen low. When the pin rises out of deep sleep, `ready` stays 0 for WAKE_CYC cycles after the edge that sees the pin high and returns to 1 at the following edge. From standby it returns at that first edge.
- R10: After reset the block is ready, not in standby or deep sleep, with the full array usable, row 0 and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_n | input | 1 | Active-low sleep pin, already synchronised |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration word {valid, mode, size} |
| ref_tick | input | 1 | Refresh interval pulse from the refresh timer |
| acc_addr | input | ADDR_W | Access word address to check |
| ref_req | output | 1 | Refresh request for the current row |
| ref_row | output | ROW_W | Row to refresh |
| addr_ok | output | 1 | Access address lies inside the usable capacity |
| ready | output | 1 | Array is available for access |
| par_active | output | 1 | Standby with bounded refresh is in effect |
| deep_sleep | output | 1 | Deep sleep is in effect |
| rms_active | output | 1 | Reduced-size limit is in effect |
| cfg_err | output | 1 | Sticky flag for a rejected configuration write |

## Verification
The address check is combinational, and `ref_req` is combinational from the tick and the mode state. The bench therefore sets these inputs at a falling edge and reads the outputs a moment later in the same cycle. All other results are registered once. The bench counts rising edges from the one that first sees the pin low or high: standby appears after edge WIN_CYC, deep sleep after edge WIN_CYC+1, the size limit after the first high edge, and `ready` after edge WAKE_CYC+1. Every sample is taken at the falling edge after the counted rising edge, including the edges just before each boundary. Window acceptance is swept over every write offset from 0 to WIN_CYC+1, and each address limit is checked over all addresses of a six-bit configuration.

// File: rtl/psr_pkg.sv
// Shared types for the pseudo-SRAM low-power controller.
// Assumes a four-quarter array split; size code n leaves 4-n quarters.
package psr_pkg;

    typedef enum logic [1:0] {
        MODE_NONE = 2'b00,
        MODE_RMS  = 2'b01,
        MODE_PAR  = 2'b10,
        MODE_DEEP = 2'b11
    } pmode_e;

    typedef struct packed {
        logic       valid;
        pmode_e     mode;
        logic [1:0] size;
    } pcfg_t;

    typedef enum logic [2:0] {
        ST_ACTIVE  = 3'd0,
        ST_WINDOW  = 3'd1,
        ST_STANDBY = 3'd2,
        ST_DEEP    = 3'd3,
        ST_WAKE    = 3'd4
    } pstate_e;

    localparam logic [1:0] SIZE_FULL = 2'b00;

    // Number of usable quarters for a size code (4, 3, 2, 1).
    function automatic logic [2:0] quarters_of(input logic [1:0] sz);
        return 3'd4 - {1'b0, sz};
    endfunction

endpackage

// File: rtl/psr_mode_ctrl.sv
// Mode state machine, configuration register and reduced-size latch.
// Assumes sleep_n is synchronous to clk. WIN_CYC >= 2, WAKE_CYC >= 1.
// The write window spans the first WIN_CYC edges that see sleep_n low.
module psr_mode_ctrl
    import psr_pkg::*;
#(
    parameter int WIN_CYC  = 125,
    parameter int WAKE_CYC = 150
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_n,
    input  logic       cfg_we,
    input  pcfg_t      cfg_wdata,
    output pstate_e    state_o,
    output pcfg_t      cfg_o,
    output logic       cfg_err_o,
    output logic       rms_on_o,
    output logic [1:0] rms_size_o
);

    localparam int CNT_MAX = (WIN_CYC > WAKE_CYC) ? WIN_CYC : WAKE_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(WIN_CYC - 2);
    localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_CYC - 1);

    pstate_e          state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    pcfg_t            cfg_q;
    logic             err_q;
    logic             rms_q;
    logic [1:0]       rms_size_q;
    logic             win_ok;
    logic             deep_sel;
    logic             rise_seen;

    // Writes are legal with the pin low in any state before the window closes.
    assign win_ok = !sleep_n &&
                    (state_q == ST_ACTIVE || state_q == ST_WAKE || state_q == ST_WINDOW);
    assign deep_sel = cfg_q.valid && (cfg_q.mode == MODE_DEEP);
    assign rise_seen = sleep_n &&
                       (state_q == ST_WINDOW || state_q == ST_STANDBY || state_q == ST_DEEP);

    // Next-state and window/wake counter logic.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (!sleep_n) begin
                    state_d = ST_WINDOW;
                    cnt_d   = '0;
                end
            end
            ST_WAKE: begin
                if (!sleep_n) begin
                    state_d = ST_WINDOW;
                    cnt_d   = '0;
                end else if (cnt_q == WAKE_LAST) begin
                    state_d = ST_ACTIVE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_WINDOW: begin
                if (sleep_n) begin
                    state_d = ST_ACTIVE;
                end else if (cnt_q == WIN_LAST) begin
                    state_d = ST_STANDBY;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_STANDBY: begin
                if (sleep_n) begin
                    state_d = ST_ACTIVE;
                end else if (deep_sel) begin
                    state_d = ST_DEEP;
                end
            end
            ST_DEEP: begin
                if (sleep_n) begin
                    state_d = ST_WAKE;
                    cnt_d   = '0;
                end
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Configuration register: loads only inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we && win_ok) begin
            cfg_q <= cfg_wdata;
        end
    end

    // Sticky error for writes that arrive outside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (cfg_we && !win_ok) begin
            err_q <= 1'b1;
        end
    end

    // Reduced-size limit, refreshed on the first high edge after a low period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rms_q      <= 1'b0;
            rms_size_q <= SIZE_FULL;
        end else if (rise_seen) begin
            rms_q      <= cfg_q.valid && (cfg_q.mode == MODE_RMS);
            rms_size_q <= (cfg_q.valid && (cfg_q.mode == MODE_RMS)) ? cfg_q.size : SIZE_FULL;
        end
    end

    assign state_o    = state_q;
    assign cfg_o      = cfg_q;
    assign cfg_err_o  = err_q;
    assign rms_on_o   = rms_q;
    assign rms_size_o = rms_size_q;

endmodule

// File: rtl/psr_refresh_gen.sv
// Refresh row counter with a size-dependent wrap point.
// Assumes ROW_W >= 2 so the array splits into four equal row quarters.
// A request is issued in the cycle the tick arrives while refresh is allowed.
module psr_refresh_gen
    import psr_pkg::*;
#(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             allow,
    input  logic [1:0]       size_code,
    output logic             req,
    output logic [ROW_W-1:0] row
);

    localparam int QSHIFT = ROW_W - 2;

    logic [ROW_W-1:0] row_q;
    logic [ROW_W:0]   span;
    logic [ROW_W:0]   last_row;
    logic             wrap;

    // Highest row of the active range, one bit wider to hold the full span.
    always_comb begin
        span     = (ROW_W + 1)'(quarters_of(size_code)) << QSHIFT;
        last_row = span - 1'b1;
        wrap     = ({1'b0, row_q} >= last_row);
    end

    assign req = tick && allow;

    // Row pointer advances once per issued request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (req) begin
            row_q <= wrap ? '0 : row_q + 1'b1;
        end
    end

    assign row = row_q;

endmodule

// File: rtl/psr_addr_limit.sv
// Address range check for reduced-size operation.
// Assumes ADDR_W >= 2; the top two address bits select the quarter.
module psr_addr_limit
    import psr_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size_code,
    output logic              ok
);

    logic [1:0] quarter;

    // Compare the quarter index with the allowed number of quarters.
    always_comb begin
        quarter = addr[ADDR_W-1 -: 2];
        ok      = ({1'b0, quarter} < quarters_of(size_code));
    end

endmodule

// File: rtl/psr_lowpower_ctrl.sv
// Top of the pseudo-SRAM low-power controller.
// Ties the mode machine to the refresh counter and the address check.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module psr_lowpower_ctrl
    import psr_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int ROW_W    = 12,
    parameter int WIN_CYC  = 125,
    parameter int WAKE_CYC = 150
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_n,
    input  logic              cfg_we,
    input  logic [4:0]        cfg_wdata,
    input  logic              ref_tick,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              ref_req,
    output logic [ROW_W-1:0]  ref_row,
    output logic              addr_ok,
    output logic              ready,
    output logic              par_active,
    output logic              deep_sleep,
    output logic              rms_active,
    output logic              cfg_err
);

    pstate_e    state;
    pcfg_t      cfg;
    logic [1:0] rms_size;
    logic [1:0] ref_size;
    logic       ref_allow;

    psr_mode_ctrl #(
        .WIN_CYC (WIN_CYC),
        .WAKE_CYC(WAKE_CYC)
    ) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_n   (sleep_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (pcfg_t'(cfg_wdata)),
        .state_o   (state),
        .cfg_o     (cfg),
        .cfg_err_o (cfg_err),
        .rms_on_o  (rms_active),
        .rms_size_o(rms_size)
    );

    // Refresh range: partial only in standby with a valid partial-refresh setting.
    always_comb begin
        ref_size  = (state == ST_STANDBY && cfg.valid && cfg.mode == MODE_PAR)
                    ? cfg.size : SIZE_FULL;
        ref_allow = (state != ST_DEEP);
    end

    psr_refresh_gen #(
        .ROW_W(ROW_W)
    ) u_refresh (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (ref_tick),
        .allow    (ref_allow),
        .size_code(ref_size),
        .req      (ref_req),
        .row      (ref_row)
    );

    psr_addr_limit #(
        .ADDR_W(ADDR_W)
    ) u_limit (
        .addr     (acc_addr),
        .size_code(rms_size),
        .ok       (addr_ok)
    );

    // Status decode from the mode state.
    always_comb begin
        ready      = (state == ST_ACTIVE);
        par_active = (state == ST_STANDBY);
        deep_sleep = (state == ST_DEEP);
    end

endmodule

// File: rtl/psr_lowpower_chk.sv
// Assertion checker for psr_lowpower_ctrl, attached through bind.
module psr_lowpower_chk #(
    parameter int ROW_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_n,
    input logic             ref_req,
    input logic [ROW_W-1:0] ref_row,
    input logic             addr_ok,
    input logic             ready,
    input logic             par_active,
    input logic             deep_sleep,
    input logic             rms_active,
    input logic             cfg_err
);

    p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    p_full_when_no_rms_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rms_active |-> addr_ok);

    p_rms_moves_on_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rms_active) |-> $past(sleep_n));

    p_row_step_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ref_req) && !$past(par_active) && !par_active
         && $past(ref_row) != '1) |-> (ref_row == $past(ref_row) + 1'b1));

    p_no_req_in_deep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        deep_sleep |-> !ref_req);

    p_not_ready_low_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n |=> !ready);

    p_deep_exit_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (deep_sleep && sleep_n) |=> (!deep_sleep && !ready));

endmodule

bind psr_lowpower_ctrl psr_lowpower_chk #(
    .ROW_W(ROW_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_n   (sleep_n),
    .ref_req   (ref_req),
    .ref_row   (ref_row),
    .addr_ok   (addr_ok),
    .ready     (ready),
    .par_active(par_active),
    .deep_sleep(deep_sleep),
    .rms_active(rms_active),
    .cfg_err   (cfg_err)
);

// File: tb/psr_lowpower_ctrl_bench.sv
module psr_lowpower_ctrl_bench;

    localparam int ADDR_W   = 6;
    localparam int ROW_W    = 4;
    localparam int WIN_CYC  = 4;
    localparam int WAKE_CYC = 3;
    localparam int NROWS    = 1 << ROW_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sleep_n = 1'b1;
    logic              cfg_we = 1'b0;
    logic [4:0]        cfg_wdata = '0;
    logic              ref_tick = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic              ref_req;
    logic [ROW_W-1:0]  ref_row;
    logic              addr_ok;
    logic              ready;
    logic              par_active;
    logic              deep_sleep;
    logic              rms_active;
    logic              cfg_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    psr_lowpower_ctrl #(
        .ADDR_W(ADDR_W), .ROW_W(ROW_W), .WIN_CYC(WIN_CYC), .WAKE_CYC(WAKE_CYC)
    ) u_psr_lowpower_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .ref_tick(ref_tick), .acc_addr(acc_addr),
        .ref_req(ref_req), .ref_row(ref_row), .addr_ok(addr_ok), .ready(ready),
        .par_active(par_active), .deep_sleep(deep_sleep),
        .rms_active(rms_active), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sleep_n = 1'b1; cfg_we = 1'b0; ref_tick = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    // Word {valid, mode, size}
    function automatic logic [4:0] word(input logic [1:0] mode, input logic [1:0] size);
        return {1'b1, mode, size};
    endfunction

    // Exhaustive address sweep against an expected quarter count.
    task automatic check_limit(input int q, input string req);
        for (int a = 0; a < (1 << ADDR_W); a++) begin
            acc_addr = ADDR_W'(a);
            #1;
            check(addr_ok == ((a >> (ADDR_W - 2)) < q), req, addr_ok, (a >> (ADDR_W - 2)) < q);
        end
    endtask

    // Pin low for hold edges, with one write at edge offset off (off < 0: none).
    task automatic sleep_low(input int off, input logic [4:0] d, input int hold);
        sleep_n = 1'b0;
        for (int k = 0; k < hold; k++) begin
            cfg_we    = (k == off);
            cfg_wdata = d;
            step();
        end
        cfg_we = 1'b0;
    endtask

    task automatic wake();
        sleep_n = 1'b1;
        step();
    endtask

    function automatic int nxt(input int prev, input int last);
        return (prev >= last) ? 0 : prev + 1;
    endfunction

    // Issue n ticks, checking that each row follows the wrap rule for last.
    task automatic run_ticks(input int n, input int last, input string req);
        int prev;
        prev = -1;
        for (int i = 0; i < n; i++) begin
            ref_tick = 1'b1;
            #1;
            check(ref_req == 1'b1, req, ref_req, 1);
            if (prev >= 0)
                check(ref_row == nxt(prev, last), req, ref_row, nxt(prev, last));
            prev = ref_row;
            step();
        end
        ref_tick = 1'b0;
    endtask

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seen_max;
        do_reset();

        // R10: reset state
        check(ready == 1, "R10 ready", ready, 1);
        check(par_active == 0, "R10 par_active", par_active, 0);
        check(deep_sleep == 0, "R10 deep_sleep", deep_sleep, 0);
        check(rms_active == 0, "R10 rms_active", rms_active, 0);
        check(cfg_err == 0, "R10 cfg_err", cfg_err, 0);
        check(ref_row == 0, "R10 ref_row", ref_row, 0);
        check(ref_req == 0, "R10 ref_req", ref_req, 0);
        check_limit(4, "R10 full array");

        // R1 / R2: sweep write offset across the window edge
        for (int off = 0; off <= WIN_CYC + 1; off++) begin
            do_reset();
            sleep_low(off, word(2'b01, 2'b11), WIN_CYC + 3);
            check(cfg_err == (off >= WIN_CYC), "R2 error flag", cfg_err, off >= WIN_CYC);
            wake();
            check_limit((off < WIN_CYC) ? 1 : 4, "R1 window acceptance");
            check(rms_active == (off < WIN_CYC), "R1 rms_active", rms_active, off < WIN_CYC);
            step();
            check(cfg_err == (off >= WIN_CYC), "R2 error sticky", cfg_err, off >= WIN_CYC);
        end

        // R2: write with pin high is ignored
        do_reset();
        cfg_we = 1'b1; cfg_wdata = word(2'b01, 2'b10);
        step();
        cfg_we = 1'b0;
        check(cfg_err == 1, "R2 pin-high write flags error", cfg_err, 1);
        sleep_low(-1, '0, WIN_CYC + 2);
        wake();
        check_limit(4, "R2 pin-high write ignored");

        // R3 / R4: every size code, limit applies only after the rise
        for (int sz = 0; sz < 4; sz++) begin
            do_reset();
            sleep_low(1, word(2'b01, 2'(sz)), WIN_CYC + 2);
            acc_addr = '1; #1;
            check(addr_ok == 1, "R4 limit not before rise", addr_ok, 1);
            wake();
            check_limit(4 - sz, "R3 size limit");
        end

        // R4: persists across a low period without a write, cleared by rewrite
        do_reset();
        sleep_low(0, word(2'b01, 2'b10), WIN_CYC + 1);
        wake();
        sleep_low(-1, '0, WIN_CYC + 5);
        wake();
        check_limit(2, "R4 limit persists");
        sleep_low(2, word(2'b00, 2'b00), WIN_CYC + 1);
        wake();
        check_limit(4, "R4 rewrite restores full");
        check(rms_active == 0, "R4 rms cleared", rms_active, 0);

        // R5: full-range refresh with the pin high, starting from row 0
        do_reset();
        ref_tick = 1'b1; #1;
        check(ref_row == 0, "R5 first row", ref_row, 0);
        ref_tick = 1'b0;
        run_ticks(NROWS + 5, NROWS - 1, "R5 full wrap");

        // R6: partial refresh over half the rows while in standby
        do_reset();
        run_ticks(11, NROWS - 1, "R5 advance");
        sleep_low(0, word(2'b10, 2'b10), WIN_CYC);
        check(par_active == 1, "R6 standby entered", par_active, 1);
        ref_tick = 1'b1; #1;
        check(ref_row == 11, "R6 row carried in", ref_row, 11);
        step();
        check(ref_row == 0, "R6 out-of-range row returns to 0", ref_row, 0);
        ref_tick = 1'b0;
        run_ticks(20, (NROWS / 2) - 1, "R6 half wrap");
        // R6 quarter size and recovery to full after rise
        do_reset();
        sleep_low(1, word(2'b10, 2'b11), WIN_CYC);
        run_ticks(12, (NROWS / 4) - 1, "R6 quarter wrap");
        wake();
        seen_max = 0;
        for (int i = 0; i < NROWS; i++) begin
            ref_tick = 1'b1; #1;
            if (ref_row > seen_max) seen_max = ref_row;
            step();
        end
        ref_tick = 1'b0;
        check(seen_max == NROWS - 1, "R6 full range after rise", seen_max, NROWS - 1);

        // R7: default behaviour with no valid register
        do_reset();
        sleep_low(-1, '0, WIN_CYC - 1);
        check(par_active == 0, "R7 window still open", par_active, 0);
        step();
        check(par_active == 1, "R7 default standby", par_active, 1);
        repeat (10) step();
        check(deep_sleep == 0, "R7 never deep", deep_sleep, 0);
        run_ticks(NROWS + 2, NROWS - 1, "R7 full-range refresh");
        wake();
        check(ready == 1, "R9 ready right after standby", ready, 1);

        // R8 / R9: deep sleep entry, blocked refresh and wake delay
        do_reset();
        sleep_low(0, word(2'b11, 2'b00), 1);
        check(ready == 0, "R9 not ready with pin low", ready, 0);
        sleep_n = 1'b0;
        repeat (WIN_CYC - 1) step();
        check(par_active == 1, "R8 standby first", par_active, 1);
        check(deep_sleep == 0, "R8 deep not yet", deep_sleep, 0);
        step();
        check(deep_sleep == 1, "R8 deep entered", deep_sleep, 1);
        ref_tick = 1'b1; #1;
        check(ref_req == 0, "R8 refresh blocked", ref_req, 0);
        step();
        check(ref_req == 0, "R8 refresh blocked later", ref_req, 0);
        ref_tick = 1'b0;
        sleep_n = 1'b1;
        for (int k = 1; k <= WAKE_CYC + 1; k++) begin
            step();
            check(ready == (k == WAKE_CYC + 1), "R9 wake delay", ready, k == WAKE_CYC + 1);
        end
        check(deep_sleep == 0, "R8 deep left", deep_sleep, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule